// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Lookup

This block is the lookup path of a small L1 data cache. In the cycle a request arrives, the set index and word select are taken straight from the virtual address. This works because those bits sit below the 4 KiB page boundary and so are identical in the virtual and the physical address. Also in that cycle, an 8-entry fully associative translation buffer maps the virtual page number, qualified by the current process identifier, to a physical page number. In the following cycle, the stored physical tags of both ways are compared against the translated address, and the block reports a hit with the selected word, a plain cache miss, or a translation miss.

Translations are tagged with the process identifier. An access can therefore only use a translation installed for its own process, and switching processes needs no flush. Translations are installed through a fill port and replaced round-robin. Cache lines are installed one word at a time through a line fill port, with an explicit target way. A global invalidate clears every translation and every line valid bit at once. Page-table walks and line replacement choice belong to the surrounding logic.

Top module: `vipt_lookup`

## Requirements
- R1: Following reset, rsp_valid, rsp_hit and rsp_tlb_miss are low and the translation buffer holds no entries, so the first lookup reports rsp_tlb_miss=1.
- R2: A request accepted on a rising edge has its result on the outputs during the next cycle only. Back-to-back requests produce back-to-back results in request order.
- R3: A lookup hits when a translation for (VA[31:12], pid) exists and the line at set VA[10:6] in either way is valid with tag equal to PA[31:11], where PA is {ppn, VA[11:0]}. rsp_data is then word VA[5:2] of that line.
- R4: The tag compare uses translated bits. If the translation succeeds but no valid line in the set has a matching physical tag (including a difference only in address bit 11), the result is rsp_hit=0 with rsp_tlb_miss=0. Two virtual pages mapped to one physical page hit the same line.
- R5: A translation installed under one process identifier never serves a request carrying another identifier. Translations for the same virtual page under different identifiers coexist and give their own physical pages.
- R6: On a translation miss, rsp_tlb_miss=1 and rsp_hit=0, whatever the cache holds.
- R7: Translation fills go to entries 0,1,...,7 in turn and then wrap around. The ninth fill after reset replaces the first one and leaves the second one usable.
- R8: One cycle of inval clears all translation and line valid bits. A request issued afterwards misses in the translation buffer, and once the translation is filled again the cache still misses until the line is refilled.
- R9: Either way of a set can hold a line. When lines from two physical pages share a set, each returns its own data.
- R10: rsp_data is zero whenever rsp_hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval | input | 1 | Clear all translation and line valid bits |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual byte address of the lookup |
| req_pid | input | 8 | Process identifier of the lookup |
| tlb_fill_en | input | 1 | Install a translation in the round-robin entry |
| tlb_fill_vpn | input | 20 | Virtual page number to install |
| tlb_fill_pid | input | 8 | Process identifier of the installed translation |
| tlb_fill_ppn | input | 20 | Physical page number to install |
| line_fill_en | input | 1 | Write one word of a line and mark the line valid |
| line_fill_way | input | 1 | Target way of the line write |
| line_fill_pa | input | 32 | Physical byte address of the written word |
| line_fill_data | input | 32 | Word written into the line |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit the cache |
| rsp_tlb_miss | output | 1 | No translation for the page and process |
| rsp_data | output | 32 | Word read on a hit, zero otherwise |

## Verification
The assertions assume that the fill logic never installs two translations for the same page and process, and never places the same physical line in both ways of a set. Under that assumption the match vectors stay one-hot or empty. They also assume that fills and lookups to the same entry or set do not land in the same cycle, since a lookup sees the state from before that edge. The directed stimulus uses distinct page/process pairs and distinct physical tags per set, and it leaves every fill idle in the cycles when requests are applied.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // Default geometry shared by the lookup modules.
  parameter int unsigned VA_BITS     = 32;
  parameter int unsigned PA_BITS     = 32;
  parameter int unsigned PAGE_BITS   = 12;
  parameter int unsigned LINE_BYTES  = 64;
  parameter int unsigned NUM_SETS    = 32;
  parameter int unsigned NUM_WAYS    = 2;
  parameter int unsigned TLB_ENTRIES = 8;
  parameter int unsigned PID_BITS    = 8;
  parameter int unsigned WORD_BITS   = 32;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb
  import vipt_pkg::*;
#(
  parameter int unsigned N     = TLB_ENTRIES,
  parameter int unsigned VPN_W = VA_BITS - PAGE_BITS,
  parameter int unsigned PPN_W = PA_BITS - PAGE_BITS,
  parameter int unsigned PID_W = PID_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inval,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             q_hit,
  output logic [PPN_W-1:0] q_ppn
);
  localparam int unsigned PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [VPN_W-1:0] ent_vpn [N];
  logic [PID_W-1:0] ent_pid [N];
  logic [PPN_W-1:0] ent_ppn [N];
  logic [N-1:0]     ent_vld;
  logic [PTR_W-1:0] rr;
  logic [N-1:0]     match;
  logic [PPN_W-1:0] sel_ppn;

  // Content-addressed compare across all entries.
  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign match[e] = ent_vld[e] && (ent_vpn[e] == lk_vpn) && (ent_pid[e] == lk_pid);
  end

  always_comb begin
    sel_ppn = '0;
    for (int e = 0; e < N; e++) begin
      if (match[e]) sel_ppn = sel_ppn | ent_ppn[e];
    end
  end

  // Entry payload: no reset needed, validity lives in ent_vld.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_vpn[rr] <= fill_vpn;
      ent_pid[rr] <= fill_pid;
      ent_ppn[rr] <= fill_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      rr      <= '0;
    end else begin
      if (fill_en) rr <= (rr == PTR_W'(N - 1)) ? '0 : rr + 1'b1;
      if (inval) ent_vld <= '0;
      else if (fill_en) ent_vld[rr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_hit <= 1'b0;
      q_ppn <= '0;
    end else if (lk_en) begin
      q_hit <= |match;
      q_ppn <= sel_ppn;
    end
  end

  // R5
  tlb_unique_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(match));
  // R7
  rr_hold_chk: assert property (@(posedge clk) disable iff (rst) !fill_en |=> $stable(rr));
  // R8
  tlb_clear_chk: assert property (@(posedge clk) disable iff (rst) inval |=> (ent_vld == '0));
endmodule

// File: rtl/vipt_way.sv
module vipt_way
  import vipt_pkg::*;
#(
  parameter int unsigned SETS   = NUM_SETS,
  parameter int unsigned WPL    = LINE_BYTES / (WORD_BITS / 8),
  parameter int unsigned TAG_W  = 21,
  parameter int unsigned DATA_W = WORD_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inval,
  input  logic                    rd_en,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  input  logic [$clog2(WPL)-1:0]  rd_word,
  input  logic                    fill_en,
  input  logic [$clog2(SETS)-1:0] fill_idx,
  input  logic [$clog2(WPL)-1:0]  fill_word,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [DATA_W-1:0]       fill_data,
  output logic                    q_valid,
  output logic [TAG_W-1:0]        q_tag,
  output logic [DATA_W-1:0]       q_data
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WS_W  = $clog2(WPL);
  localparam int unsigned DEPTH = SETS * WPL;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [SETS-1:0]   vld;

  // Tag store: synchronous write and read, block RAM shaped.
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
    if (rd_en)   q_tag <= tag_mem[rd_idx];
  end

  // Data store addressed by {set, word}.
  always_ff @(posedge clk) begin
    if (fill_en) data_mem[{fill_idx, fill_word}] <= fill_data;
    if (rd_en)   q_data <= data_mem[{rd_idx, rd_word}];
  end

  // Valid bits in flops so a single cycle clears them all.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      q_valid <= 1'b0;
    end else begin
      if (inval) vld <= '0;
      else if (fill_en) vld[fill_idx] <= 1'b1;
      if (rd_en) q_valid <= vld[rd_idx];
    end
  end

  // R8
  line_clear_chk: assert property (@(posedge clk) disable iff (rst) inval |=> (vld == '0));
  // R3
  fill_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !inval) |=> vld[$past(fill_idx)]);

  logic unused_w;
  assign unused_w = ^{IDX_W[0], WS_W[0]};
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned VA_W       = VA_BITS,
  parameter int unsigned PA_W       = PA_BITS,
  parameter int unsigned PAGE_W     = PAGE_BITS,
  parameter int unsigned LINE_B     = LINE_BYTES,
  parameter int unsigned SETS       = NUM_SETS,
  parameter int unsigned WAYS       = NUM_WAYS,
  parameter int unsigned TLB_N      = TLB_ENTRIES,
  parameter int unsigned PID_W      = PID_BITS,
  parameter int unsigned DATA_W     = WORD_BITS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inval,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_va,
  input  logic [PID_W-1:0]          req_pid,
  input  logic                      tlb_fill_en,
  input  logic [VA_W-PAGE_W-1:0]    tlb_fill_vpn,
  input  logic [PID_W-1:0]          tlb_fill_pid,
  input  logic [PA_W-PAGE_W-1:0]    tlb_fill_ppn,
  input  logic                      line_fill_en,
  input  logic [$clog2(WAYS)-1:0]   line_fill_way,
  input  logic [PA_W-1:0]           line_fill_pa,
  input  logic [DATA_W-1:0]         line_fill_data,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic                      rsp_tlb_miss,
  output logic [DATA_W-1:0]         rsp_data
);
  localparam int unsigned OFF_W  = $clog2(LINE_B);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned BSEL_W = $clog2(DATA_W / 8);
  localparam int unsigned WS_W   = OFF_W - BSEL_W;
  localparam int unsigned WPL    = LINE_B / (DATA_W / 8);
  localparam int unsigned LOW_W  = OFF_W + IDX_W;      // must not exceed PAGE_W
  localparam int unsigned VPN_W  = VA_W - PAGE_W;
  localparam int unsigned PPN_W  = PA_W - PAGE_W;
  localparam int unsigned TAG_W  = PA_W - LOW_W;
  localparam int unsigned MID_W  = PAGE_W - LOW_W;
  localparam int unsigned WAY_W  = $clog2(WAYS);

  // Index and word select come from untranslated page-offset bits.
  logic [IDX_W-1:0] rd_idx;
  logic [WS_W-1:0]  rd_word;
  assign rd_idx  = req_va[LOW_W-1:OFF_W];
  assign rd_word = req_va[OFF_W-1:BSEL_W];

  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;

  vipt_tlb #(
    .N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)
  ) u_tlb (
    .clk      (clk),
    .rst      (rst),
    .inval    (inval),
    .lk_en    (req_valid),
    .lk_vpn   (req_va[VA_W-1:PAGE_W]),
    .lk_pid   (req_pid),
    .fill_en  (tlb_fill_en),
    .fill_vpn (tlb_fill_vpn),
    .fill_pid (tlb_fill_pid),
    .fill_ppn (tlb_fill_ppn),
    .q_hit    (tlb_hit),
    .q_ppn    (tlb_ppn)
  );

  // Request stage register.
  logic v_q;
  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= req_valid;
  end

  // Physical tag built from the translated page and the page-offset bits above the index.
  logic [TAG_W-1:0] tag_pa;
  if (MID_W > 0) begin : g_mid
    logic [MID_W-1:0] mid_q;
    always_ff @(posedge clk) begin
      if (rst) mid_q <= '0;
      else if (req_valid) mid_q <= req_va[PAGE_W-1:LOW_W];
    end
    assign tag_pa = {tlb_ppn, mid_q};
  end else begin : g_nomid
    assign tag_pa = tlb_ppn;
  end

  // Line fill address split.
  logic [IDX_W-1:0] fill_idx;
  logic [WS_W-1:0]  fill_word;
  logic [TAG_W-1:0] fill_tag;
  assign fill_idx  = line_fill_pa[LOW_W-1:OFF_W];
  assign fill_word = line_fill_pa[OFF_W-1:BSEL_W];
  assign fill_tag  = line_fill_pa[PA_W-1:LOW_W];

  logic              way_v   [WAYS];
  logic [TAG_W-1:0]  way_tag [WAYS];
  logic [DATA_W-1:0] way_dat [WAYS];
  logic [WAYS-1:0]   way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic fill_here;
    assign fill_here = line_fill_en && (line_fill_way == WAY_W'(w));

    vipt_way #(
      .SETS(SETS), .WPL(WPL), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_way (
      .clk       (clk),
      .rst       (rst),
      .inval     (inval),
      .rd_en     (req_valid),
      .rd_idx    (rd_idx),
      .rd_word   (rd_word),
      .fill_en   (fill_here),
      .fill_idx  (fill_idx),
      .fill_word (fill_word),
      .fill_tag  (fill_tag),
      .fill_data (line_fill_data),
      .q_valid   (way_v[w]),
      .q_tag     (way_tag[w]),
      .q_data    (way_dat[w])
    );

    assign way_hit[w] = way_v[w] && (way_tag[w] == tag_pa);
  end

  logic [DATA_W-1:0] sel_data;
  always_comb begin
    sel_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) sel_data = sel_data | way_dat[w];
    end
  end

  logic any_hit;
  assign any_hit      = v_q && tlb_hit && (|way_hit);
  assign rsp_valid    = v_q;
  assign rsp_tlb_miss = v_q && !tlb_hit;
  assign rsp_hit      = any_hit;
  assign rsp_data     = any_hit ? sel_data : '0;

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid);
  // R6
  miss_excl_chk: assert property (@(posedge clk) disable iff (rst) rsp_tlb_miss |-> !rsp_hit);
  // R9
  way_unique_chk: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $onehot0(way_hit));
  // R10
  data_zero_chk: assert property (@(posedge clk) disable iff (rst) !rsp_hit |-> (rsp_data == '0));

  logic unused_bits;
  assign unused_bits = ^{req_va[BSEL_W-1:0], line_fill_pa[BSEL_W-1:0]};
endmodule

// File: tb/vipt_lookup_test.sv
module vipt_lookup_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inval = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_pid = '0;
  logic        tlb_fill_en = 1'b0;
  logic [19:0] tlb_fill_vpn = '0;
  logic [7:0]  tlb_fill_pid = '0;
  logic [19:0] tlb_fill_ppn = '0;
  logic        line_fill_en = 1'b0;
  logic        line_fill_way = 1'b0;
  logic [31:0] line_fill_pa = '0;
  logic [31:0] line_fill_data = '0;
  logic        rsp_valid, rsp_hit, rsp_tlb_miss;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vipt_lookup uut (
    .clk(clk), .rst(rst), .inval(inval),
    .req_valid(req_valid), .req_va(req_va), .req_pid(req_pid),
    .tlb_fill_en(tlb_fill_en), .tlb_fill_vpn(tlb_fill_vpn),
    .tlb_fill_pid(tlb_fill_pid), .tlb_fill_ppn(tlb_fill_ppn),
    .line_fill_en(line_fill_en), .line_fill_way(line_fill_way),
    .line_fill_pa(line_fill_pa), .line_fill_data(line_fill_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_tlb_miss(rsp_tlb_miss), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tlb_fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [19:0] ppn);
    @(negedge clk);
    tlb_fill_en = 1'b1; tlb_fill_vpn = vpn; tlb_fill_pid = pid; tlb_fill_ppn = ppn;
    @(negedge clk);
    tlb_fill_en = 1'b0;
  endtask

  task automatic line_fill(input logic way, input logic [31:0] pa, input logic [31:0] data);
    @(negedge clk);
    line_fill_en = 1'b1; line_fill_way = way; line_fill_pa = pa; line_fill_data = data;
    @(negedge clk);
    line_fill_en = 1'b0;
  endtask

  // Single lookup: result is sampled at the negedge after the accepting edge.
  task automatic look(input string tag, input logic [31:0] va, input logic [7:0] pid,
                      input logic ehit, input logic emiss, input logic [31:0] edata);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_pid = pid;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " hit"}, 32'(rsp_hit), 32'(ehit));
    chk({tag, " tlb_miss"}, 32'(rsp_tlb_miss), 32'(emiss));
    chk({tag, " data"}, rsp_data, edata);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset hit", 32'(rsp_hit), 32'd0);
    chk("R1 reset tlb_miss", 32'(rsp_tlb_miss), 32'd0);
    look("R1 empty tlb", 32'h1234_57C8, 8'd1, 1'b0, 1'b1, 32'd0);
  endtask

  task automatic t_basic_hit;
    tlb_fill(20'h12345, 8'd1, 20'h00ABC);
    line_fill(1'b0, 32'h00AB_C7C8, 32'hCAFE_0001);
    line_fill(1'b0, 32'h00AB_C7CC, 32'hCAFE_0003);
    look("R3 hit word2", 32'h1234_57C8, 8'd1, 1'b1, 1'b0, 32'hCAFE_0001);
    look("R3 hit word3", 32'h1234_57CC, 8'd1, 1'b1, 1'b0, 32'hCAFE_0003);
    @(negedge clk);
    chk("R2 one-cycle result", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h1234_57C8; req_pid = 8'd1;
    @(negedge clk);
    req_va = 32'h1234_57CC;
    chk("R2 first of pair", rsp_data, 32'hCAFE_0001);
    chk("R2 first valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 second of pair", rsp_data, 32'hCAFE_0003);
    chk("R2 second valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk("R2 pair drains", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_two_ways;
    tlb_fill(20'h22222, 8'd1, 20'h00DEF);
    line_fill(1'b1, 32'h00DE_F7C8, 32'hBEEF_0002);
    look("R9 way1 line", 32'h2222_27C8, 8'd1, 1'b1, 1'b0, 32'hBEEF_0002);
    look("R9 way0 line", 32'h1234_57C8, 8'd1, 1'b1, 1'b0, 32'hCAFE_0001);
  endtask

  task automatic t_tag_miss;
    tlb_fill(20'h33333, 8'd1, 20'h00777);
    look("R4 tag mismatch", 32'h3333_37C8, 8'd1, 1'b0, 1'b0, 32'd0);
    look("R4 bit11 differs", 32'h1234_5FC8, 8'd1, 1'b0, 1'b0, 32'd0);
    look("R10 miss zero data", 32'h3333_37CC, 8'd1, 1'b0, 1'b0, 32'd0);
  endtask

  task automatic t_alias;
    tlb_fill(20'h44444, 8'd1, 20'h00ABC);
    look("R4 alias hits", 32'h4444_47C8, 8'd1, 1'b1, 1'b0, 32'hCAFE_0001);
  endtask

  task automatic t_pid;
    look("R5 foreign pid", 32'h1234_57C8, 8'd2, 1'b0, 1'b1, 32'd0);
    tlb_fill(20'h12345, 8'd2, 20'h00DEF);
    look("R5 pid2 own page", 32'h1234_57C8, 8'd2, 1'b1, 1'b0, 32'hBEEF_0002);
    look("R5 pid1 unchanged", 32'h1234_57C8, 8'd1, 1'b1, 1'b0, 32'hCAFE_0001);
  endtask

  task automatic t_round_robin;
    // Entries 0..4 used so far; fill 5..7, then the ninth fill wraps to entry 0.
    for (int i = 0; i < 3; i++) tlb_fill(20'h50000 + 20'(i), 8'd1, 20'h00111);
    tlb_fill(20'h60000, 8'd1, 20'h00ABC);
    look("R7 oldest evicted", 32'h1234_57C8, 8'd1, 1'b0, 1'b1, 32'd0);
    look("R7 second kept", 32'h2222_27C8, 8'd1, 1'b1, 1'b0, 32'hBEEF_0002);
    look("R7 new entry", 32'h6000_07C8, 8'd1, 1'b1, 1'b0, 32'hCAFE_0001);
  endtask

  task automatic t_invalidate;
    @(negedge clk);
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    look("R8 tlb cleared", 32'h2222_27C8, 8'd1, 1'b0, 1'b1, 32'd0);
    tlb_fill(20'h22222, 8'd1, 20'h00DEF);
    look("R8 lines cleared", 32'h2222_27C8, 8'd1, 1'b0, 1'b0, 32'd0);
    line_fill(1'b1, 32'h00DE_F7C8, 32'hBEEF_0005);
    look("R8 refill hits", 32'h2222_27C8, 8'd1, 1'b1, 1'b0, 32'hBEEF_0005);
    look("R6 miss despite line", 32'h4444_47C8, 8'd1, 1'b0, 1'b1, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_hit();
    t_pipeline();
    t_two_ways();
    t_tag_miss();
    t_alias();
    t_pid();
    t_round_robin();
    t_invalidate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule